// File: doc/BRIEF.md
# Sixteen-Bit Up-Counting Timer with Selectable Wrap Point

This block is a 16-bit up-counter that advances once per timer clock. The timer clock comes from one of three sources: nothing, a prescaled tick input, or a rising or falling edge on an external pin that is synchronised to the system clock. The counter wraps back to zero at a wrap point, called TOP. A three-bit mode input chooses TOP from three fixed values, from the active compare-A value, or from a separate capture register. Whatever the mode, the counter always wraps after the all-ones value.

Two compare channels watch the counter all the time. Each channel gives a one-cycle pulse when the counter holds that channel's value at a timer clock. Software writes compare values into a buffer. In buffered modes the buffer moves to the active compare register only when the counter wraps. This lets the period and duty values change while the timer runs without a torn cycle. In unbuffered modes a write takes effect at once.

A single write port loads the counter, the two compare buffers and the capture register. After a counter write, the compare match on the next timer clock is suppressed, so a reload does not raise a spurious match.

Top module: `wide_timer`

## Requirements
- R1: After reset the counter, both compare registers (active and buffer) and the capture register are 0, and all three pulse outputs are low.
- R2: Clock select: 0 gives no timer clock and the counter holds. 1 uses `pre_tick`. 2 counts rising edges of `ext_pin` and 3 counts falling edges. A pin edge first sampled at rising clock edge k advances the counter at edge k+2.
- R3: On each timer clock the counter increments by one. If it is at TOP or at 0xFFFF, it goes to 0 instead.
- R4: TOP by mode: 0 = 0xFFFF; 1 = 0x00FF; 2 = 0x01FF; 3 = 0x03FF; 4 and 6 = active compare-A value; 5 and 7 = capture register.
- R5: `ovf_pulse` is high for exactly the clock cycle after each timer clock at which the counter wrapped to 0.
- R6: `cmpa_pulse` (`cmpb_pulse`) is high for the clock cycle after a timer clock at which the counter equalled the active compare-A (compare-B) value.
- R7: In modes 1, 2, 3, 6 and 7, compare writes go only to the buffer. The active value takes the buffer at the timer clock where the counter wraps.
- R8: In modes 0, 4 and 5, a compare write updates the active value at the same clock edge.
- R9: Write address 0 loads the counter. This takes priority over any timer clock in that cycle, and that cycle produces no pulse. The next timer clock after the load produces no compare pulse.
- R10: Write address 3 loads the capture register. In modes 5 and 7 it is TOP from the next timer clock onward. Addresses 1 and 2 select the compare-A and compare-B buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Timer clock source select |
| pre_tick | input | 1 | Prescaled timer clock enable |
| ext_pin | input | 1 | External event pin (asynchronous) |
| mode | input | 3 | TOP and buffering mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 counter, 1 cmp A, 2 cmp B, 3 capture |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| ovf_pulse | output | 1 | Wrap-to-zero pulse |
| cmpa_pulse | output | 1 | Compare A match pulse |
| cmpb_pulse | output | 1 | Compare B match pulse |

## Verification
A wrong TOP or a missed wrap shows at once: `count` passes the expected wrap point, and `ovf_pulse` is missing on the very next cycle. A wrong active compare value is harder to see. In buffered modes it stays hidden until the counter passes the stale value, and then `cmpa_pulse` or `cmpb_pulse` fires at the wrong count or not at all. That can take up to a full period. A lost load-block or a wrong external-edge delay moves one pulse or one increment by exactly one cycle. For this reason the bench compares every output on every cycle against a reference model.

// File: rtl/wide_timer.sv
module wide_timer #(
  parameter int W = 16,
  parameter logic [W-1:0] FIX_TOP1 = 16'h00FF,
  parameter logic [W-1:0] FIX_TOP2 = 16'h01FF,
  parameter logic [W-1:0] FIX_TOP3 = 16'h03FF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   clk_sel,
  input  logic         pre_tick,
  input  logic         ext_pin,
  input  logic [2:0]   mode,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         ovf_pulse,
  output logic         cmpa_pulse,
  output logic         cmpb_pulse
);
  localparam logic [W-1:0] MAXV = '1;

  logic [1:0]   ext_sync;
  logic         ext_prev;
  logic         tick;
  logic [W-1:0] ocra_act, ocrb_act, ocra_buf, ocrb_buf, cap_reg;
  logic [W-1:0] top;
  logic         blk;

  wire ext_rise = ext_sync[1] & ~ext_prev;
  wire ext_fall = ~ext_sync[1] & ext_prev;

  always_comb begin
    case (clk_sel)
      2'd1:    tick = pre_tick;
      2'd2:    tick = ext_rise;
      2'd3:    tick = ext_fall;
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      3'd1:         top = FIX_TOP1;
      3'd2:         top = FIX_TOP2;
      3'd3:         top = FIX_TOP3;
      3'd4, 3'd6:   top = ocra_act;
      3'd5, 3'd7:   top = cap_reg;
      default:      top = MAXV;
    endcase
  end

  wire buffered = (mode != 3'd0) && (mode != 3'd4) && (mode != 3'd5);
  wire cnt_wr   = wr_en && (wr_addr == 2'd0);
  wire adv      = tick && !cnt_wr;
  wire at_top   = (count == top) || (count == MAXV);
  wire wrap     = adv && at_top;
  wire wr_a     = wr_en && (wr_addr == 2'd1);
  wire wr_b     = wr_en && (wr_addr == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sync <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_sync <= {ext_sync[0], ext_pin};
      ext_prev <= ext_sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      blk   <= 1'b0;
    end else if (cnt_wr) begin
      count <= wr_data;
      blk   <= 1'b1;
    end else if (adv) begin
      count <= at_top ? '0 : count + 1'b1;
      blk   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocra_buf <= '0;
      ocrb_buf <= '0;
      ocra_act <= '0;
      ocrb_act <= '0;
      cap_reg  <= '0;
    end else begin
      if (wr_a) ocra_buf <= wr_data;
      if (wr_b) ocrb_buf <= wr_data;
      if (wr_en && wr_addr == 2'd3) cap_reg <= wr_data;
      if (buffered) begin
        if (wrap) begin
          ocra_act <= ocra_buf;
          ocrb_act <= ocrb_buf;
        end
      end else begin
        if (wr_a) ocra_act <= wr_data;
        if (wr_b) ocrb_act <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_pulse  <= 1'b0;
      cmpa_pulse <= 1'b0;
      cmpb_pulse <= 1'b0;
    end else begin
      ovf_pulse  <= wrap;
      cmpa_pulse <= adv && !blk && (count == ocra_act);
      cmpb_pulse <= adv && !blk && (count == ocrb_act);
    end
  end
endmodule

// File: rtl/wide_timer_chk.sv
module wide_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   clk_sel,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic         ovf_pulse,
  input logic         cmpa_pulse,
  input logic         cmpb_pulse,
  input logic [W-1:0] ocra_act,
  input logic [W-1:0] ocrb_act
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd0 && !(wr_en && wr_addr == 2'd0)) |=> $stable(count)); // R2
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (count == '0)); // R5
  AST_CMPA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpa_pulse) |-> ($past(count) == $past(ocra_act))); // R6
  AST_CMPB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpb_pulse) |-> ($past(count) == $past(ocrb_act))); // R6
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (count == $past(wr_data))); // R9
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> !(ovf_pulse || cmpa_pulse || cmpb_pulse)); // R9
endmodule

bind wide_timer wide_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
  .ovf_pulse(ovf_pulse), .cmpa_pulse(cmpa_pulse), .cmpb_pulse(cmpb_pulse),
  .ocra_act(ocra_act), .ocrb_act(ocrb_act)
);

// File: tb/wide_timer_bench.sv
module wide_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  clk_sel = 2'd0;
  logic        pre_tick = 1'b0;
  logic        ext_pin = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] count;
  logic        ovf_pulse, cmpa_pulse, cmpb_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_timer u_wide_timer (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .pre_tick(pre_tick),
    .ext_pin(ext_pin), .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .ovf_pulse(ovf_pulse),
    .cmpa_pulse(cmpa_pulse), .cmpb_pulse(cmpb_pulse)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt, m_a, m_b, m_abuf, m_bbuf, m_cap;
  logic        m_ovf, m_ca, m_cb, m_blk, m_s1, m_s2, m_d;

  function automatic logic [15:0] ref_top(input logic [2:0] md, input logic [15:0] a, input logic [15:0] c);
    case (md)
      3'd1: return 16'h00FF;
      3'd2: return 16'h01FF;
      3'd3: return 16'h03FF;
      3'd4, 3'd6: return a;
      3'd5, 3'd7: return c;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic bit ref_buffered(input logic [2:0] md);
    return !(md == 3'd0 || md == 3'd4 || md == 3'd5);
  endfunction

  always @(posedge clk) begin
    logic tk, cw, adv, wrap;
    logic [15:0] tp;
    if (!rst_n) begin
      m_cnt = 0; m_a = 0; m_b = 0; m_abuf = 0; m_bbuf = 0; m_cap = 0;
      m_ovf = 0; m_ca = 0; m_cb = 0; m_blk = 0; m_s1 = 0; m_s2 = 0; m_d = 0;
    end else begin
      case (clk_sel)
        2'd1: tk = pre_tick;
        2'd2: tk = m_s2 & ~m_d;
        2'd3: tk = ~m_s2 & m_d;
        default: tk = 1'b0;
      endcase
      m_d = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
      cw   = wr_en && wr_addr == 2'd0;
      adv  = tk && !cw;
      tp   = ref_top(mode, m_a, m_cap);
      wrap = adv && (m_cnt == tp || m_cnt == 16'hFFFF);
      m_ovf = wrap;
      m_ca  = adv && !m_blk && m_cnt == m_a;
      m_cb  = adv && !m_blk && m_cnt == m_b;
      if (ref_buffered(mode)) begin
        if (wrap) begin m_a = m_abuf; m_b = m_bbuf; end
      end else begin
        if (wr_en && wr_addr == 2'd1) m_a = wr_data;
        if (wr_en && wr_addr == 2'd2) m_b = wr_data;
      end
      if (wr_en && wr_addr == 2'd1) m_abuf = wr_data;
      if (wr_en && wr_addr == 2'd2) m_bbuf = wr_data;
      if (wr_en && wr_addr == 2'd3) m_cap = wr_data;
      if (cw) begin m_cnt = wr_data; m_blk = 1'b1; end
      else if (adv) begin m_cnt = wrap ? 16'd0 : m_cnt + 16'd1; m_blk = 1'b0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(count == m_cnt, "R3 count", count, m_cnt);
      chk(ovf_pulse == m_ovf, "R5 ovf", 16'(ovf_pulse), 16'(m_ovf));
      chk(cmpa_pulse == m_ca, "R6 cmpa", 16'(cmpa_pulse), 16'(m_ca));
      chk(cmpb_pulse == m_cb, "R6 cmpb", 16'(cmpb_pulse), 16'(m_cb));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0;
    int seed;
    seed = $urandom(32'd2024);
    cyc(3);
    chk(count == 0 && !ovf_pulse && !cmpa_pulse && !cmpb_pulse, "R1 reset", count, 16'd0);
    rst_n = 1'b1;
    cyc(2);
    chk(count == 0, "R1 after reset hold", count, 16'd0);

    // R2: no source selected holds the count
    mode = 3'd0; clk_sel = 2'd0; pre_tick = 1'b1;
    wr(2'd0, 16'h0040);
    c0 = count;
    cyc(5);
    chk(count == c0, "R2 no source", count, c0);

    // R2: external rising edge advances at edge k+2
    clk_sel = 2'd2; ext_pin = 1'b0;
    cyc(3);
    c0 = count;
    ext_pin = 1'b1;
    cyc(2);
    chk(count == c0, "R2 ext latency", count, c0);
    cyc(1);
    chk(count == c0 + 16'd1, "R2 ext rise", count, c0 + 16'd1);
    ext_pin = 1'b0;
    cyc(3);
    chk(count == c0 + 16'd1, "R2 falling ignored in rise mode", count, c0 + 16'd1);

    // R9 and R4: load then wrap at fixed 0x00FF
    clk_sel = 2'd1; mode = 3'd1;
    wr(2'd0, 16'h00FE);
    chk(count == 16'h00FE, "R9 load", count, 16'h00FE);
    cyc(2);
    chk(count == 16'h0000 && ovf_pulse, "R4 fixed top wrap", count, 16'h0000);

    // R10: capture register as TOP
    mode = 3'd5;
    wr(2'd3, 16'h0003);
    wr(2'd0, 16'h0000);
    cyc(4);
    chk(count == 16'h0000 && ovf_pulse, "R10 capture top", count, 16'h0000);

    // R8: unbuffered compare write is immediate
    mode = 3'd0;
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'h0024);
    cyc(3);
    cyc(1);
    chk(cmpa_pulse == 1'b1, "R8 immediate compare", 16'(cmpa_pulse), 16'd1);

    // R7: buffered write stays pending until wrap
    mode = 3'd1;
    wr(2'd0, 16'h0028);
    wr(2'd1, 16'h002C);
    cyc(4);
    chk(cmpa_pulse == 1'b0, "R7 buffered pending", 16'(cmpa_pulse), 16'd0);
    wr(2'd0, 16'h00FF);
    cyc(1);
    chk(count == 16'h0000, "R7 wrap", count, 16'h0000);
    cyc(16'h002C);
    cyc(1);
    chk(cmpa_pulse == 1'b1, "R7 buffered applied", 16'(cmpa_pulse), 16'd1);

    // R9: load onto the compare value blocks the next match
    wr(2'd0, 16'h002C);
    cyc(1);
    chk(cmpa_pulse == 1'b0 && count == 16'h002D, "R9 match blocked", count, 16'h002D);

    // random phase
    for (int i = 0; i < 40000; i++) begin
      if (i % 500 == 0) begin
        mode = 3'($urandom % 8);
        clk_sel = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'd1;
      end
      pre_tick = ($urandom % 4) != 0;
      if ($urandom % 3 == 0) ext_pin = ~ext_pin;
      wr_en = ($urandom % 24) == 0;
      wr_addr = 2'($urandom % 4);
      case (wr_addr)
        2'd0: wr_data = ($urandom % 8 == 0) ? 16'hFFF8 + 16'($urandom % 8) : 16'($urandom % 16'h0400);
        2'd3: wr_data = 16'h0020 + 16'($urandom % 16'h03E0);
        default: wr_data = 16'($urandom % 16'h0400);
      endcase
      cyc(1);
    end
    wr_en = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule